// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counter intended as the heartbeat of a processor subsystem. Software loads a period into a reload register and selects a count source: either every cycle of the core clock, or each rising edge of a slow reference clock that arrives asynchronously. It then sets the run bit. Whenever the counter steps from one to zero, the block raises a sticky flag and, if enabled, emits a single-cycle interrupt pulse. On the next tick the counter reloads the period and starts again.

Four 32-bit word registers sit behind a minimal one-cycle register port:

| Word index | Byte offset | Register |
|---|---|---|
| 0 | 0x0 | control/status |
| 1 | 0x4 | reload |
| 2 | 0x8 | current count |
| 3 | 0xC | calibration (read-only) |

Reads are combinational while `bus_sel` is high. Any side effect of an access, whether a write or a flag-clearing read, takes effect at the clock edge that samples it.

The run control is a two-state machine:
- `ST_HALT` moves to `ST_RUN` when the control register is written with bit 0 set.
- `ST_RUN` returns to `ST_HALT` when the control register is written with bit 0 clear.

The calibration word is fixed by parameters. It tells software whether a reference clock exists, whether its period is inexact, and how many reference ticks make up 10 ms.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, the control, reload and current registers read 0 and `tick_irq` is low.
- R2: `bus_word` selects the register: 0 for control, 1 for reload, 2 for current count, 3 for calibration. Reads with `bus_sel` low return 0.
- R3: Control bit 0 is the run bit; it reads back as 1 only in `ST_RUN`. While it is 0, the count holds its value.
- R4: Control bit 2 selects the count source. A 1 selects the core clock, giving one tick per cycle. A 0 selects the reference input, which passes through a two-flop synchronizer and rising-edge detection and gives one tick per detected edge.
- R5: On a tick, a count of 0 loads the reload value; any other count decrements by one. The count is 24 bits wide, so its largest value is 0xFFFFFF.
- R6: Any write to the current register clears the count to 0 and clears the flag, whatever the write data. It takes priority over a tick in the same cycle.
- R7: Control bit 16 is a sticky flag. It is set when a tick moves the count from 1 to 0. It is cleared by a read of the control register, but a set in the same cycle takes priority.
- R8: When control bit 1 is set, `tick_irq` is high for exactly the one cycle after a tick that moves the count from 1 to 0.
- R9: The calibration register reads as bit 31 = no-reference parameter, bit 30 = skew parameter, bits 23:0 = ten-millisecond tick count. Writes to it have no effect.
- R10: Writes to the reload register keep bits 23:0 only. All unused register bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high |
| tick_irq | output | 1 | One-cycle interrupt pulse on each 1-to-0 step of the count |

## Verification
The assertions take three things for granted:
- Each register access is a single-cycle strobe.
- Bus inputs change only away from the rising clock edge.
- Each level of the reference input lasts at least one full core-clock cycle, so no reference edge can slip between synchronizer samples.

The stimulus keeps within these assumptions:
- It drives every input on the falling edge and holds it for a whole cycle.
- It toggles the reference input at most once per cycle.
- It keeps reload values small in the random phase, so that wraps, flag sets and interrupt pulses happen often.

// File: rtl/systick_pkg.sv
package systick_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CUR    = 2'd2,
        SEL_CAL    = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int REG_W     = 32;
    localparam int BIT_RUN   = 0;
    localparam int BIT_IE    = 1;
    localparam int BIT_SRC   = 2;
    localparam int BIT_FLAG  = 16;
    localparam int BIT_SKEW  = 30;
    localparam int BIT_NOREF = 31;
    localparam int CAL_CNT_W = 24;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= ref_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign ref_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import systick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_run,
    input  logic             wr_ie,
    input  logic             wr_src,
    input  logic             ctrl_rd,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             cur_wr,
    input  logic             ref_rise,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             irq_en,
    output logic             src_core,
    output logic             flag,
    output logic             irq
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             ie_q, src_q, flag_q, irq_q;
    logic             tick, hit_zero;

    // run-control state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && wr_run)  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wr_run) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    assign tick     = (state_q == ST_RUN) && (src_q || ref_rise);
    assign hit_zero = tick && !cur_wr && (count_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cur_wr) begin
            count_q <= '0;
        end else if (tick) begin
            if (count_q == '0) count_q <= reload_q;
            else               count_q <= count_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ie_q     <= 1'b0;
            src_q    <= 1'b0;
        end else begin
            if (reload_wr) reload_q <= reload_wdata;
            if (ctrl_wr) begin
                ie_q  <= wr_ie;
                src_q <= wr_src;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= hit_zero && ie_q;
            if (hit_zero)               flag_q <= 1'b1;
            else if (cur_wr || ctrl_rd) flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        count    = count_q;
        reload   = reload_q;
        running  = (state_q == ST_RUN);
        irq_en   = ie_q;
        src_core = src_q;
        flag     = flag_q;
        irq      = irq_q;
    end

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import systick_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter logic             CAL_NOREF = 1'b0,
    parameter logic             CAL_SKEW  = 1'b1,
    parameter logic [CAL_CNT_W-1:0] CAL_TENMS = 24'd500
) (
    input  logic             bus_sel,
    input  logic             bus_write,
    input  logic [1:0]       bus_word,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] reload,
    input  logic             running,
    input  logic             irq_en,
    input  logic             src_core,
    input  logic             flag,
    output logic             ctrl_wr,
    output logic             ctrl_rd,
    output logic             reload_wr,
    output logic             cur_wr,
    output logic             wr_run,
    output logic             wr_ie,
    output logic             wr_src,
    output logic [CNT_W-1:0] reload_wdata,
    output logic [REG_W-1:0] bus_rdata
);

    localparam int PAD_W = REG_W - CNT_W;

    reg_sel_e sel;
    logic     wdata_unused;

    assign sel          = reg_sel_e'(bus_word);
    assign ctrl_wr      = bus_sel &&  bus_write && (sel == SEL_CTRL);
    assign ctrl_rd      = bus_sel && !bus_write && (sel == SEL_CTRL);
    assign reload_wr    = bus_sel &&  bus_write && (sel == SEL_RELOAD);
    assign cur_wr       = bus_sel &&  bus_write && (sel == SEL_CUR);
    assign wr_run       = bus_wdata[BIT_RUN];
    assign wr_ie        = bus_wdata[BIT_IE];
    assign wr_src       = bus_wdata[BIT_SRC];
    assign reload_wdata = bus_wdata[CNT_W-1:0];
    assign wdata_unused = ^bus_wdata[REG_W-1:CNT_W];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (sel)
                SEL_CTRL: begin
                    bus_rdata[BIT_RUN]  = running;
                    bus_rdata[BIT_IE]   = irq_en;
                    bus_rdata[BIT_SRC]  = src_core;
                    bus_rdata[BIT_FLAG] = flag;
                end
                SEL_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload};
                SEL_CUR:    bus_rdata = {{PAD_W{1'b0}}, count};
                SEL_CAL: begin
                    bus_rdata[CAL_CNT_W-1:0] = CAL_TENMS;
                    bus_rdata[BIT_SKEW]      = CAL_SKEW;
                    bus_rdata[BIT_NOREF]     = CAL_NOREF;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import systick_pkg::*;
#(
    parameter int                   CNT_W       = 24,
    parameter int                   SYNC_STAGES = 2,
    parameter logic                 CAL_NOREF   = 1'b0,
    parameter logic                 CAL_SKEW    = 1'b1,
    parameter logic [CAL_CNT_W-1:0] CAL_TENMS   = 24'd500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_clk_in,
    input  logic        bus_sel,
    input  logic        bus_write,
    input  logic [1:0]  bus_word,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tick_irq
);

    logic             ref_rise;
    logic             ctrl_wr, ctrl_rd, reload_wr, cur_wr;
    logic             wr_run, wr_ie, wr_src;
    logic [CNT_W-1:0] reload_wdata;
    logic [CNT_W-1:0] cnt_val, cnt_reload;
    logic             cnt_running, cnt_ie, cnt_src, cnt_flag;

    tick_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_clk_in),
        .ref_rise (ref_rise)
    );

    tick_regs #(
        .CNT_W     (CNT_W),
        .CAL_NOREF (CAL_NOREF),
        .CAL_SKEW  (CAL_SKEW),
        .CAL_TENMS (CAL_TENMS)
    ) u_regs (
        .bus_sel      (bus_sel),
        .bus_write    (bus_write),
        .bus_word     (bus_word),
        .bus_wdata    (bus_wdata),
        .count        (cnt_val),
        .reload       (cnt_reload),
        .running      (cnt_running),
        .irq_en       (cnt_ie),
        .src_core     (cnt_src),
        .flag         (cnt_flag),
        .ctrl_wr      (ctrl_wr),
        .ctrl_rd      (ctrl_rd),
        .reload_wr    (reload_wr),
        .cur_wr       (cur_wr),
        .wr_run       (wr_run),
        .wr_ie        (wr_ie),
        .wr_src       (wr_src),
        .reload_wdata (reload_wdata),
        .bus_rdata    (bus_rdata)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .wr_run       (wr_run),
        .wr_ie        (wr_ie),
        .wr_src       (wr_src),
        .ctrl_rd      (ctrl_rd),
        .reload_wr    (reload_wr),
        .reload_wdata (reload_wdata),
        .cur_wr       (cur_wr),
        .ref_rise     (ref_rise),
        .count        (cnt_val),
        .reload       (cnt_reload),
        .running      (cnt_running),
        .irq_en       (cnt_ie),
        .src_core     (cnt_src),
        .flag         (cnt_flag),
        .irq          (tick_irq)
    );

endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             running,
    input logic             cur_wr
);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0));

    assert_irq_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_cur_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (count == '0) && !flag);

    assert_halt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cur_wr) |=> $stable(count));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cur_wr && count != '0) |=>
            (count == $past(count)) || (count == $past(count) - CNT_W'(1)));

endmodule

bind sys_tick_timer sys_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (tick_irq),
    .count   (cnt_val),
    .flag    (cnt_flag),
    .running (cnt_running),
    .cur_wr  (cur_wr)
);

// File: tb/tb_sys_tick_timer.sv
`timescale 1ns/1ps
module tb_sys_tick_timer;

    localparam logic [31:0] CAL_EXP = 32'h4000_01F4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    bit        m_run, m_ie, m_src, m_flag, m_irq;
    bit [23:0] m_cnt, m_rel;
    bit        m_s1, m_s2, m_s3;

    always #2 clk = ~clk;

    sys_tick_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_in (ref_clk_in),
        .bus_sel    (bus_sel),
        .bus_write  (bus_write),
        .bus_word   (bus_word),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_irq   (tick_irq)
    );

    // expected behaviour, stepped at each edge from the bench's own inputs
    always @(posedge clk) begin
        bit e, tk, hit, wc, rc, wctl, wrel;
        if (!rst_n) begin
            m_run = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
            m_cnt = 0; m_rel = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            e    = m_s2 & ~m_s3;
            tk   = m_run && (m_src || e);
            wc   = bus_sel && bus_write && bus_word == 2'd2;
            rc   = bus_sel && !bus_write && bus_word == 2'd0;
            wctl = bus_sel && bus_write && bus_word == 2'd0;
            wrel = bus_sel && bus_write && bus_word == 2'd1;
            hit  = tk && !wc && m_cnt == 24'd1;
            m_irq = hit && m_ie;
            if (hit)           m_flag = 1;
            else if (wc || rc) m_flag = 0;
            if (wc)            m_cnt = 0;
            else if (tk)       m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 24'd1;
            if (wctl) begin
                m_run = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (wrel) m_rel = bus_wdata[23:0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_clk_in;
        end
    end

    function automatic logic [31:0] exp_read(input logic [1:0] w);
        case (w)
            2'd0:    return {15'd0, m_flag, 13'd0, m_src, m_ie, m_run};
            2'd1:    return {8'd0, m_rel};
            2'd2:    return {8'd0, m_cnt};
            default: return CAL_EXP;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] w);
        case (w)
            2'd0:    return "R7";
            2'd1:    return "R10";
            2'd2:    return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_write = 1; bus_word = w; bus_wdata = d;
    endtask

    task automatic rd(input logic [1:0] w, input string req, output logic [31:0] got);
        @(negedge clk);
        bus_sel = 1; bus_write = 0; bus_word = w; bus_wdata = $urandom;
        #1;
        got = bus_rdata;
        chk(req, got, exp_read(w));
    endtask

    task automatic idle();
        @(negedge clk);
        bus_sel = 0; bus_write = 0;
    endtask

    // interrupt monitor against the model (R8)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R8", {31'd0, tick_irq}, {31'd0, m_irq});
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        int pulses;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state, R2 decode
        chk("R1", {31'd0, tick_irq}, 32'd0);
        rd(2'd0, "R1", v); chk("R1", v, 32'd0);
        rd(2'd1, "R1", v); chk("R1", v, 32'd0);
        rd(2'd2, "R1", v); chk("R1", v, 32'd0);
        rd(2'd3, "R2", v); chk("R2", v, CAL_EXP);
        idle(); #1; chk("R2", bus_rdata, 32'd0);

        // R10 reload truncation
        wr(2'd1, 32'hFFAB_CDEF);
        rd(2'd1, "R10", v); chk("R10", v, 32'h00AB_CDEF);

        // R5 maximum value and load from zero
        wr(2'd1, 32'h00FF_FFFF);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h5);
        rd(2'd2, "R5", v);  chk("R5", v, 32'd0);
        rd(2'd2, "R5", v);  chk("R5", v, 32'h00FF_FFFF);
        rd(2'd2, "R5", v);  chk("R5", v, 32'h00FF_FFFE);
        wr(2'd0, 32'h4);

        // R8 interrupt pulses, core clock, period reload+1
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h7);
        pulses = 0;
        for (int i = 0; i < 17; i++) begin
            idle(); #1;
            if (tick_irq) pulses++;
        end
        chk("R8", pulses, 32'd4);

        // R7 flag sticky, cleared by control read
        wr(2'd0, 32'h4);
        rd(2'd0, "R7", v); chk("R7", v[16], 1'b1);
        rd(2'd0, "R7", v); chk("R7", v[16], 1'b0);

        // R3 hold while halted
        wr(2'd0, 32'h5);
        repeat (3) idle();
        wr(2'd0, 32'h4);
        rd(2'd2, "R3", v);
        repeat (5) idle();
        rd(2'd2, "R3", v2); chk("R3", v2, v);
        rd(2'd0, "R3", v2); chk("R3", v2[0], 1'b0);

        // R6 clear with all-ones data
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, "R6", v); chk("R6", v, 32'd0);

        // R4 reference source: five edges -> load 100 then four steps
        wr(2'd1, 32'd100);
        wr(2'd0, 32'h1);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk); bus_sel = 0; ref_clk_in = 1;
            repeat (2) idle();
            @(negedge clk); ref_clk_in = 0;
            repeat (2) idle();
        end
        repeat (4) idle();
        rd(2'd2, "R4", v); chk("R4", v, 32'd96);
        wr(2'd0, 32'h0);

        // R9 calibration write ignored
        wr(2'd3, 32'h0);
        rd(2'd3, "R9", v); chk("R9", v, CAL_EXP);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            if ($urandom_range(0, 2) == 0) begin
                @(negedge clk); ref_clk_in = ~ref_clk_in; bus_sel = 0;
            end
            case (op)
                0: begin
                    d = $urandom;
                    if ($urandom_range(0, 7) != 0) d[0] = 1'b1;
                    wr(2'd0, d);
                end
                1: wr(2'd1, {$urandom_range(0, 255), 24'd0} | 32'($urandom_range(0, 12)));
                2: wr(2'd2, $urandom);
                3, 4, 5, 6: begin
                    logic [1:0] w;
                    w = 2'($urandom_range(0, 3));
                    rd(w, tag_of(w), v);
                end
                7: wr(2'd3, $urandom);
                default: idle();
            endcase
        end
        idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule